// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a virtual page number after the translation cache has missed. It accepts one walk at a time. Each walk carries a 20-bit virtual page number, an access kind and a privilege flag. At acceptance it captures the per-process table base, then reads two 32-bit words through a memory port that uses a request/valid handshake. The first word is a directory entry and the second is the leaf entry it points to. The 12-bit page offset never enters the block, because 4 KB pages leave it unchanged.

A walk ends with a one-cycle response. The response carries the frame number and the permission bits to be placed in the translation cache, or one fault code. The fault code separates invalid addresses, pages that are not resident, and privilege or protection violations. On success the block updates the usage history in memory. It sets the referenced bit of the leaf entry, and also the modified bit when the access is a write. It issues this write only if a bit actually changes.

Entry layout, used for both levels: bits 31:12 hold the frame number. The low byte holds the control flags: bit 0 valid, bit 1 resident, bit 2 readable, bit 3 writable, bit 4 executable, bit 5 user-accessible, bit 6 referenced, bit 7 modified. A directory entry uses only its valid bit and its frame field.

Top module: `ptw_top`

## Requirements
- R1: After reset, `req_ready` is 1 and both `mem_req` and `rsp_valid` are 0.
- R2: The first memory read of a walk goes to the byte address {ptbr[31:12], vpn[19:10], 2'b00}, where `ptbr` is sampled when the walk is accepted.
- R3: The second read goes to {dir[31:12], vpn[9:0], 2'b00}, where `dir` is the directory word returned by the first read.
- R4: If bit 0 of the directory word is 0, the walk ends with fault code 1 and makes no further memory access.
- R5: If the leaf valid bit (bit 0) is 0, the fault code is 2. If the leaf is valid but its resident bit (bit 1) is 0, the fault code is 3.
- R6: An access with `req_user`=1 to a leaf whose user bit (bit 5) is 0 gives fault code 4.
- R7: Access kinds are 0 read, 1 write and 2 execute. They need leaf bit 2, 3 and 4 respectively. Kind 3 is never permitted. A missing permission gives fault code 5.
- R8: Exactly one code is reported per walk. When several conditions hold, the first in this order wins: 1, 2, 3, 4, 5.
- R9: On success, `rsp_fault` is 0, `rsp_pfn` is leaf[31:12] and `rsp_perm` is {U, X, W, R} taken from leaf bits 5, 4, 3 and 2. On any fault, `rsp_pfn` and `rsp_perm` are 0.
- R10: On success the leaf is written back to its own address with bit 6 set, and with bit 7 also set for a write access. All other bits are unchanged. No write is issued when the new value equals the old one.
- R11: `req_ready` is 0 from the cycle after acceptance until the cycle after the response. `rsp_valid` is a one-cycle pulse. `mem_req` stays high with stable address and write flag until `mem_valid` arrives, whatever the number of wait cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Walk request strobe |
| req_ready | output | 1 | Block is idle and can accept a walk |
| req_vpn | input | 20 | Virtual page number to translate |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| req_user | input | 1 | 1 for a user-mode access |
| ptbr | input | 32 | Page table base of the current process |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | 32 | Byte address of the word to access |
| mem_wdata | output | 32 | Write data |
| mem_valid | input | 1 | Access complete; read data is valid |
| mem_rdata | input | 32 | Read data |
| rsp_valid | output | 1 | Walk result pulse |
| rsp_fault | output | 3 | Fault code, 0 for success |
| rsp_pfn | output | 20 | Physical frame number |
| rsp_perm | output | 4 | Permissions {U, X, W, R} |

## Verification
The properties assume that the memory side raises `mem_valid` for exactly one cycle, only while `mem_req` is high. They also assume that `req_valid` is asserted only when the requester intends to be accepted. The bench memory model keeps to this contract. It answers each request after a random delay of zero to three cycles and drops `mem_valid` at the next falling edge. The request driver waits for `req_ready` before it presents a walk, so no request overlaps a busy walk. Random table contents and random access kinds exercise the fault ordering and the write-back rules. Directed entries add the combinations in which several fault conditions hold at once.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    localparam int ADDR_W = 32;
    localparam int OFS_W  = 12;
    localparam int IDX_W  = 10;
    localparam int LEVELS = 2;
    localparam int VPN_W  = IDX_W * LEVELS;
    localparam int PFN_W  = ADDR_W - OFS_W;
    localparam int WORD_B = 2;   // log2 of the entry size in bytes

    typedef enum logic [1:0] {
        ACC_RD  = 2'd0,
        ACC_WR  = 2'd1,
        ACC_EX  = 2'd2,
        ACC_RSV = 2'd3
    } acc_e;

    typedef enum logic [2:0] {
        FLT_NONE     = 3'd0,
        FLT_DIR_INV  = 3'd1,
        FLT_LEAF_INV = 3'd2,
        FLT_ABSENT   = 3'd3,
        FLT_PRIV     = 3'd4,
        FLT_PROT     = 3'd5
    } flt_e;

    typedef struct packed {
        logic [PFN_W-1:0] frame;
        logic [3:0]       rsvd;
        logic             dirty;
        logic             refd;
        logic             user;
        logic             ex;
        logic             wr;
        logic             rd;
        logic             present;
        logic             valid;
    } pte_t;

    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_DIR  = 3'd1,
        S_LEAF = 3'd2,
        S_WB   = 3'd3,
        S_RESP = 3'd4
    } st_e;

    function automatic logic [ADDR_W-1:0] entry_addr(
        input logic [PFN_W-1:0] frame,
        input logic [IDX_W-1:0] idx
    );
        return {frame, idx, {WORD_B{1'b0}}};
    endfunction

endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
    import ptw_pkg::*;
(
    input  logic [PFN_W-1:0]  root_frame,
    input  logic [PFN_W-1:0]  tbl_frame,
    input  logic [VPN_W-1:0]  vpn,
    input  logic              sel_leaf,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] lvl_addr [LEVELS];

    for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
        // level 0 uses the upper index field, level 1 the lower one
        localparam int HI = VPN_W - 1 - g * IDX_W;
        if (g == 0) begin : g_root
            assign lvl_addr[g] = entry_addr(root_frame, vpn[HI -: IDX_W]);
        end else begin : g_tbl
            assign lvl_addr[g] = entry_addr(tbl_frame, vpn[HI -: IDX_W]);
        end
    end

    assign addr = sel_leaf ? lvl_addr[1] : lvl_addr[0];
endmodule

// File: rtl/ptw_fault_check.sv
module ptw_fault_check
    import ptw_pkg::*;
(
    input  pte_t  leaf,
    input  acc_e  acc,
    input  logic  user,
    output flt_e  fault,
    output pte_t  upd,
    output logic  wb_need
);
    logic allowed;

    always_comb begin
        unique case (acc)
            ACC_RD:  allowed = leaf.rd;
            ACC_WR:  allowed = leaf.wr;
            ACC_EX:  allowed = leaf.ex;
            default: allowed = 1'b0;
        endcase

        if (!leaf.valid)            fault = FLT_LEAF_INV;
        else if (!leaf.present)     fault = FLT_ABSENT;
        else if (user && !leaf.user) fault = FLT_PRIV;
        else if (!allowed)          fault = FLT_PROT;
        else                        fault = FLT_NONE;

        upd = leaf;
        upd.refd = 1'b1;
        if (acc == ACC_WR) upd.dirty = 1'b1;

        wb_need = (fault == FLT_NONE) && (upd != leaf);
    end
endmodule

// File: rtl/ptw_top.sv
module ptw_top
    import ptw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VPN_W-1:0]  req_vpn,
    input  logic [1:0]        req_acc,
    input  logic              req_user,
    input  logic [ADDR_W-1:0] ptbr,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [ADDR_W-1:0] mem_wdata,
    input  logic              mem_valid,
    input  logic [ADDR_W-1:0] mem_rdata,
    output logic              rsp_valid,
    output logic [2:0]        rsp_fault,
    output logic [PFN_W-1:0]  rsp_pfn,
    output logic [3:0]        rsp_perm
);
    st_e              state;
    logic [VPN_W-1:0] vpn_q;
    acc_e             acc_q;
    logic             user_q;
    logic [PFN_W-1:0] root_q;
    logic [PFN_W-1:0] tbl_q;
    pte_t             upd_q;
    flt_e             fault_q;
    logic [PFN_W-1:0] pfn_q;
    logic [3:0]       perm_q;

    pte_t rd_pte;
    flt_e chk_fault;
    pte_t chk_upd;
    logic chk_wb;

    assign rd_pte = pte_t'(mem_rdata);

    ptw_addr_gen i_addr (
        .root_frame (root_q),
        .tbl_frame  (tbl_q),
        .vpn        (vpn_q),
        .sel_leaf   (state != S_DIR),
        .addr       (mem_addr)
    );

    ptw_fault_check i_chk (
        .leaf    (rd_pte),
        .acc     (acc_q),
        .user    (user_q),
        .fault   (chk_fault),
        .upd     (chk_upd),
        .wb_need (chk_wb)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= S_IDLE;
            vpn_q   <= '0;
            acc_q   <= ACC_RD;
            user_q  <= 1'b0;
            root_q  <= '0;
            tbl_q   <= '0;
            upd_q   <= '0;
            fault_q <= FLT_NONE;
            pfn_q   <= '0;
            perm_q  <= '0;
        end else begin
            unique case (state)
                S_IDLE: if (req_valid) begin
                    vpn_q  <= req_vpn;
                    acc_q  <= acc_e'(req_acc);
                    user_q <= req_user;
                    root_q <= ptbr[ADDR_W-1:OFS_W];
                    state  <= S_DIR;
                end
                S_DIR: if (mem_valid) begin
                    if (!rd_pte.valid) begin
                        fault_q <= FLT_DIR_INV;
                        pfn_q   <= '0;
                        perm_q  <= '0;
                        state   <= S_RESP;
                    end else begin
                        tbl_q <= rd_pte.frame;
                        state <= S_LEAF;
                    end
                end
                S_LEAF: if (mem_valid) begin
                    fault_q <= chk_fault;
                    upd_q   <= chk_upd;
                    if (chk_fault == FLT_NONE) begin
                        pfn_q  <= rd_pte.frame;
                        perm_q <= {rd_pte.user, rd_pte.ex, rd_pte.wr, rd_pte.rd};
                    end else begin
                        pfn_q  <= '0;
                        perm_q <= '0;
                    end
                    state <= chk_wb ? S_WB : S_RESP;
                end
                S_WB:   if (mem_valid) state <= S_RESP;
                S_RESP: state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    assign req_ready = (state == S_IDLE);
    assign mem_req   = (state == S_DIR) || (state == S_LEAF) || (state == S_WB);
    assign mem_we    = (state == S_WB);
    assign mem_wdata = upd_q;
    assign rsp_valid = (state == S_RESP);
    assign rsp_fault = fault_q;
    assign rsp_pfn   = pfn_q;
    assign rsp_perm  = perm_q;
endmodule

// File: rtl/ptw_checker.sv
module ptw_checker
    import ptw_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [ADDR_W-1:0] mem_wdata,
    input logic              mem_valid,
    input logic              rsp_valid,
    input logic [2:0]        rsp_fault,
    input logic [PFN_W-1:0]  rsp_pfn,
    input logic [3:0]        rsp_perm
);
    // R11: a request that has not completed is held unchanged
    a_r11_req_hold: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_valid |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    // R11: no new walk is accepted while memory is being accessed
    a_r11_busy: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !req_ready);

    // R11: the response is a single-cycle pulse followed by idle
    a_r11_rsp_pulse: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid && req_ready);

    // R9: faulting walks return no frame and no permissions
    a_r9_fault_zero: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && (rsp_fault != 3'd0) |-> (rsp_pfn == '0) && (rsp_perm == '0));

    // R8: only defined codes are reported
    a_r8_code_range: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> rsp_fault <= 3'd5);

    // R10: every write-back carries the referenced bit
    a_r10_wb_ref: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> mem_req && mem_wdata[6]);

    // R10: a write-back always ends in a successful response
    a_r10_wb_success: assert property (@(posedge clk) disable iff (rst)
        mem_we && mem_valid |=> rsp_valid && (rsp_fault == 3'd0));
endmodule

bind ptw_top ptw_checker i_ptw_checker (
    .clk       (clk),
    .rst       (rst),
    .req_ready (req_ready),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_valid (mem_valid),
    .rsp_valid (rsp_valid),
    .rsp_fault (rsp_fault),
    .rsp_pfn   (rsp_pfn),
    .rsp_perm  (rsp_perm)
);

// File: tb/test_ptw_top.sv
module test_ptw_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [19:0] req_vpn = '0;
    logic [1:0]  req_acc = '0;
    logic        req_user = 1'b0;
    logic [31:0] ptbr = 32'h0010_0000;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_valid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        rsp_valid;
    logic [2:0]  rsp_fault;
    logic [19:0] rsp_pfn;
    logic [3:0]  rsp_perm;

    int n_chk = 0;
    int n_fail = 0;

    logic [31:0] mem [bit [31:0]];
    int          n_rd, n_wr, wt;
    logic [31:0] rd_a0, rd_a1, wr_a, wr_d;

    always #10 clk = ~clk;   // 50 MHz

    ptw_top i_ptw_top (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_vpn(req_vpn), .req_acc(req_acc), .req_user(req_user), .ptbr(ptbr),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_valid(mem_valid), .mem_rdata(mem_rdata),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_pfn(rsp_pfn),
        .rsp_perm(rsp_perm)
    );

    function automatic logic [31:0] rdm(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    function automatic logic [2:0] exp_fault(input logic [31:0] d, input logic [31:0] l,
                                             input logic [1:0] acc, input bit usr);
        bit ok;
        ok = (acc == 2'd0) ? l[2] : (acc == 2'd1) ? l[3] : (acc == 2'd2) ? l[4] : 1'b0;
        if (!d[0])            return 3'd1;
        if (!l[0])            return 3'd2;
        if (!l[1])            return 3'd3;
        if (usr && !l[5])     return 3'd4;
        if (!ok)              return 3'd5;
        return 3'd0;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // memory responder: random 0..3 wait cycles, one-cycle valid
    initial begin
        wt = 0;
        forever begin
            @(negedge clk);
            if (mem_valid) begin
                mem_valid = 1'b0;
                wt = int'($urandom % 4);
            end else if (mem_req && !rst) begin
                if (wt == 0) begin
                    if (mem_we) begin
                        mem[mem_addr] = mem_wdata;
                        wr_a = mem_addr; wr_d = mem_wdata; n_wr++;
                    end else begin
                        mem_rdata = rdm(mem_addr);
                        if (n_rd == 0) rd_a0 = mem_addr;
                        if (n_rd == 1) rd_a1 = mem_addr;
                        n_rd++;
                    end
                    mem_valid = 1'b1;
                end else begin
                    wt--;
                end
            end
        end
    end

    task automatic walk(input logic [19:0] vpn, input logic [1:0] acc, input bit usr);
        logic [31:0] da, d, la, l, upd;
        logic [2:0]  ef;
        bit          ewb;
        int          cyc;
        string       ft;
        da = {ptbr[31:12], vpn[19:10], 2'b00};
        d  = rdm(da);
        la = {d[31:12], vpn[9:0], 2'b00};
        l  = d[0] ? rdm(la) : 32'h0;
        ef = exp_fault(d, l, acc, usr);
        upd = l | 32'h40 | ((acc == 2'd1) ? 32'h80 : 32'h0);
        ewb = (ef == 3'd0) && (upd != l);
        n_rd = 0; n_wr = 0;
        @(negedge clk);
        req_valid = 1'b1; req_vpn = vpn; req_acc = acc; req_user = usr;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R11 ready low while busy", {31'b0, req_ready}, 32'd0);
        cyc = 0;
        while (!rsp_valid && cyc < 300) begin @(negedge clk); cyc++; end
        chk("R11 response arrives", {31'b0, rsp_valid}, 32'd1);
        case (ef)
            3'd1: ft = "R4 directory invalid";
            3'd2, 3'd3: ft = "R5 leaf invalid/absent";
            3'd4: ft = "R6 privilege";
            3'd5: ft = "R7 protection";
            default: ft = "R8 success code";
        endcase
        chk(ft, {29'b0, rsp_fault}, {29'b0, ef});
        chk("R9 frame", {12'b0, rsp_pfn}, (ef == 0) ? {12'b0, l[31:12]} : 32'h0);
        chk("R9 perm", {28'b0, rsp_perm}, (ef == 0) ? {28'b0, l[5:2]} : 32'h0);
        chk("R2 directory address", rd_a0, da);
        chk("R4 read count", n_rd, d[0] ? 2 : 1);
        if (d[0]) chk("R3 leaf address", rd_a1, la);
        chk("R10 write count", n_wr, ewb ? 1 : 0);
        if (ewb) begin
            chk("R10 write address", wr_a, la);
            chk("R10 write data", wr_d, upd);
        end
        @(negedge clk);
        chk("R11 pulse ends, ready back", {30'b0, rsp_valid, req_ready}, 32'd1);
    endtask

    task automatic set_leaf(input int di, input int ti, input logic [31:0] v);
        mem[32'h0020_0000 + di * 32'h1000 + ti * 4] = v;
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'h1234_5678));
        for (int di = 0; di < 8; di++)
            mem[ptbr + di * 4] = {20'h00200 + 20'(di), 11'b0, (di != 3)};
        for (int di = 0; di < 8; di++)
            for (int ti = 0; ti < 16; ti++) begin
                logic [31:0] v;
                v = {$urandom} & 32'hFFFF_F0FF;
                v[0] = ($urandom % 8) != 0;
                v[1] = ($urandom % 8) != 0;
                set_leaf(di, ti, v);
            end
        // directed entries in table 0
        set_leaf(0, 0, 32'h1110_003F);  // V P R W X U, unreferenced
        set_leaf(0, 1, 32'h2220_00FF);  // everything set
        set_leaf(0, 2, 32'h3330_003E);  // not valid
        set_leaf(0, 3, 32'h4440_0001);  // valid, absent, no rights, kernel
        set_leaf(0, 4, 32'h5550_0007);  // V P R, kernel only
        set_leaf(0, 5, 32'h6660_0027);  // V P R U
        set_leaf(0, 6, 32'h7770_0013);  // V P X kernel
        set_leaf(0, 7, 32'h8880_0067);  // V P R U Ref

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset outputs", {29'b0, req_ready, mem_req, rsp_valid}, 32'd4);

        walk(20'h00000, 2'd0, 1'b1);   // R10 ref write-back
        walk(20'h00000, 2'd1, 1'b0);   // R10 dirty write-back
        walk(20'h00001, 2'd1, 1'b1);   // R10 no change, no write
        walk(20'h00002, 2'd0, 1'b0);   // R5 invalid leaf
        walk(20'h00003, 2'd1, 1'b1);   // R8 absent wins over privilege/protection
        walk(20'h00004, 2'd0, 1'b1);   // R6 user to kernel page
        walk(20'h00004, 2'd0, 1'b0);   // R6 supervisor allowed
        walk(20'h00005, 2'd1, 1'b1);   // R7 write to read-only
        walk(20'h00006, 2'd2, 1'b0);   // R7 execute allowed
        walk(20'h00007, 2'd0, 1'b1);   // R10 already referenced
        walk(20'h00001, 2'd3, 1'b0);   // R7 reserved kind
        walk({10'd3, 10'd0}, 2'd0, 1'b0); // R4 invalid directory
        walk({10'd9, 10'd5}, 2'd1, 1'b1); // R4 unpopulated directory
        for (int k = 0; k < 60; k++)
            walk({10'($urandom % 8), 10'($urandom % 16)}, 2'($urandom % 3), 1'($urandom % 2));

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule